// File: doc/BRIEF.md
# SPI Slave Serial Engine with Error Detection

This block is the slave side of a four-wire synchronous serial port. It sits on a small internal register bus. The external clock, select and data-in pins are asynchronous to the system clock, so each passes through a synchroniser. Clock edges are found by comparing successive synchronised samples. Characters of one to eight bits are shifted most-significant bit first. Software loads the transmit character into the data register before the remote master starts clocking. When a character completes, the received bits land in the same register address for reading, and a completion flag is raised that can drive an interrupt.

Three error conditions are detected and held in sticky status flags, each cleared by writing one to its bit:
- a write collision, where software writes the data register while a transfer is open;
- a mode fault, where the unit is set up as an enabled master and some other device drives its select pin active;
- an abort, where select is released part way through a character.

The register port accepts a single-cycle write on any clock and never stalls, so there is no back-pressure on the bus side. The serial side is paced entirely by the remote master; there is no handshake, and the only rule is the minimum clock half-period in R11. Reads are combinational from the address.

Register map (address: content):
- 0: written as the transmit character, read as the last received character.
- 1: status. Bit 0 is done, bit 1 is collision, bit 2 is abort, bit 3 is fault, and bit 4 is busy (read-only).
- 2: control. Bit 0 enables the unit, bit 1 selects master, bit 2 makes the select pin an input, bit 3 sets clock polarity, bit 4 sets clock phase, and bit 5 enables the interrupt.
- 3: character length.

Top module: `spi_slave_eng`

## Requirements
- R1: The unit acts as a slave only when control bit 0 is 1, bit 1 is 0 and bit 2 is 1; otherwise clock edges set no done flag and MISO is never enabled.
- R2: `miso_oe_o` is high only while the synchronised select is low in slave mode, and low whenever select is high.
- R3: The length field (address 3, bits 2:0) gives the character length, with 0 meaning 8 bits. Bits shift MSB first. At the last sampled bit, the low bits of register 0 take the received character (upper bits zero) and status bit 0 is set.
- R4: With polarity 0 the leading edge is rising, and with polarity 1 it is falling. With phase 0, MOSI is sampled on the leading edge and MISO changes on the trailing edge. With phase 1, MISO changes on the leading edge and MOSI is sampled on the trailing edge.
- R5: The transmit character is taken from the data register when select asserts and again after each completed character, so with no new write every character under one select repeats it.
- R6: A write to address 0 while select is asserted in slave mode sets status bit 1 and leaves the transmit character unchanged.
- R7: With control bits 0 and 1 both set, an asserted select sets status bit 3.
- R8: Releasing select after at least one bit but before the last bit sets status bits 2 and 0. It leaves register 0 unchanged, and the next character starts again from its first bit.
- R9: Writing 1 to status bits 0 to 3 clears them, and writing 0 leaves them. A flag event in the same cycle wins over the clear.
- R10: `irq_o` is high exactly while status bit 0 and control bit 5 are both 1.
- R11: A serial clock with half-periods of four system clocks is received without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data |
| sck_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for MISO |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong bit counter or a wrong reload of the transmit shifter shows up at MISO within the same character as a misplaced bit. It also makes register 0 read back a shifted value as soon as that character completes. A missed or spurious completion or abort shows up in the status word and on `irq_o` a few system clocks after the select or clock edge that caused it. An error in the edge selection shows up as received characters and MISO bits that are off by one bit for that polarity and phase. The bench sweeps every polarity, phase and character length against arithmetic expectations, and then works through each error flag's set and clear paths.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  // register addresses
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_FMT  = 2'd3;
  // status bit positions
  localparam int ST_DONE = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_ABT  = 2;
  localparam int ST_FLT  = 3;
  localparam int ST_BUSY = 4;
  localparam int ST_W    = 5;
  // control bit positions
  localparam int CT_EN   = 0;
  localparam int CT_MST  = 1;
  localparam int CT_SSIN = 2;
  localparam int CT_CPOL = 3;
  localparam int CT_CPHA = 4;
  localparam int CT_IE   = 5;
  localparam int CT_W    = 6;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } clk_mode_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
  import spi_slv_pkg::*;
#(
  parameter int DW = 8,
  parameter int LENW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active_i,
  input  clk_mode_t       mode_i,
  input  logic [LENW-1:0] len_code_i,
  input  logic [DW-1:0]   tx_data_i,
  input  logic            sck_s_i,
  input  logic            ss_n_s_i,
  input  logic            mosi_s_i,
  output logic            miso_o,
  output logic            miso_oe_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            abort_o,
  output logic [DW-1:0]   rx_o,
  output logic [LENW-1:0] cnt_o,
  output logic [LENW:0]   nbits_o
);
  localparam logic [LENW:0] FULL = (LENW+1)'(DW);
  localparam logic [DW-1:0] ONE  = DW'(1);

  logic            sck_q, ss_q, fresh_q;
  logic [DW-1:0]   tx_sh, rx_sh;
  logic [LENW-1:0] cnt_q;

  logic [LENW:0]   nbits;
  logic [DW-1:0]   mask, aligned, rx_next;
  logic            last, sel, ss_fall, lead, trail, smp, shf, sck_a, sck_b;

  always_comb begin
    nbits   = (len_code_i == '0) ? FULL : {1'b0, len_code_i};
    mask    = (ONE << nbits) - ONE;
    aligned = tx_data_i << (FULL - nbits);
    last    = ({1'b0, cnt_q} == (nbits - 1'b1));
    rx_next = {rx_sh[DW-2:0], mosi_s_i};
  end

  // edge classification relative to the idle level
  assign sck_a   = sck_s_i ^ mode_i.cpol;
  assign sck_b   = sck_q ^ mode_i.cpol;
  assign lead    = sck_a & ~sck_b;
  assign trail   = ~sck_a & sck_b;
  assign sel     = active_i & ~ss_n_s_i;
  assign ss_fall = sel & ss_q;
  assign smp     = sel & ~ss_fall & (mode_i.cpha ? trail : lead);
  assign shf     = sel & ~ss_fall & (mode_i.cpha ? lead : trail);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      ss_q    <= 1'b1;
      fresh_q <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      cnt_q   <= '0;
    end else begin
      sck_q <= sck_s_i;
      ss_q  <= ss_n_s_i;
      if (!sel) begin
        cnt_q <= '0;
      end else if (ss_fall) begin
        tx_sh   <= aligned;
        fresh_q <= mode_i.cpha;
        cnt_q   <= '0;
      end else if (smp) begin
        rx_sh <= rx_next;
        if (last) begin
          cnt_q   <= '0;
          tx_sh   <= aligned;
          fresh_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (shf) begin
        if (fresh_q) fresh_q <= 1'b0;
        else tx_sh <= {tx_sh[DW-2:0], 1'b0};
      end
    end
  end

  assign miso_o    = tx_sh[DW-1];
  assign miso_oe_o = sel;
  assign busy_o    = sel;
  assign done_o    = smp & last;
  assign abort_o   = active_i & ss_n_s_i & ~ss_q & (cnt_q != '0);
  assign rx_o      = rx_next & mask;
  assign cnt_o     = cnt_q;
  assign nbits_o   = nbits;
endmodule

// File: rtl/spi_slv_regs.sv
module spi_slv_regs
  import spi_slv_pkg::*;
#(
  parameter int DW = 8,
  parameter int LENW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            ev_done_i,
  input  logic            ev_abort_i,
  input  logic [DW-1:0]   ev_rx_i,
  input  logic            busy_i,
  input  logic            ss_n_s_i,
  output logic [DW-1:0]   tx_data_o,
  output logic            slave_o,
  output clk_mode_t       mode_o,
  output logic [LENW-1:0] len_code_o,
  output logic [CT_W-1:0] ctrl_o,
  output logic [ST_W-1:0] stat_o,
  output logic            irq_o
);
  logic [CT_W-1:0] ctrl_q;
  logic [LENW-1:0] fmt_q;
  logic [DW-1:0]   tx_q, rx_q;
  logic            done_q, ovr_q, abt_q, flt_q;
  logic            w_data, w_stat, fault_ev, clr_done, clr_ovr, clr_abt, clr_flt;

  assign w_data   = wr_i & (addr_i == A_DATA);
  assign w_stat   = wr_i & (addr_i == A_STAT);
  assign fault_ev = ctrl_q[CT_EN] & ctrl_q[CT_MST] & ~ss_n_s_i;
  assign clr_done = w_stat & wdata_i[ST_DONE];
  assign clr_ovr  = w_stat & wdata_i[ST_OVR];
  assign clr_abt  = w_stat & wdata_i[ST_ABT];
  assign clr_flt  = w_stat & wdata_i[ST_FLT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fmt_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      abt_q  <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_CTRL) ctrl_q <= wdata_i[CT_W-1:0];
      if (wr_i && addr_i == A_FMT)  fmt_q  <= wdata_i[LENW-1:0];
      if (w_data && !busy_i) tx_q <= wdata_i;
      if (ev_done_i) rx_q <= ev_rx_i;
      // event beats clear
      if (ev_done_i || ev_abort_i) done_q <= 1'b1;
      else if (clr_done)           done_q <= 1'b0;
      if (w_data && busy_i)        ovr_q  <= 1'b1;
      else if (clr_ovr)            ovr_q  <= 1'b0;
      if (ev_abort_i)              abt_q  <= 1'b1;
      else if (clr_abt)            abt_q  <= 1'b0;
      if (fault_ev)                flt_q  <= 1'b1;
      else if (clr_flt)            flt_q  <= 1'b0;
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o[ST_DONE] = done_q;
    stat_o[ST_OVR]  = ovr_q;
    stat_o[ST_ABT]  = abt_q;
    stat_o[ST_FLT]  = flt_q;
    stat_o[ST_BUSY] = busy_i;
    rdata_o = '0;
    case (addr_i)
      A_DATA:  rdata_o = rx_q;
      A_STAT:  rdata_o[ST_W-1:0] = stat_o;
      A_CTRL:  rdata_o[CT_W-1:0] = ctrl_q;
      default: rdata_o[LENW-1:0] = fmt_q;
    endcase
  end

  assign tx_data_o   = tx_q;
  assign slave_o     = ctrl_q[CT_EN] & ~ctrl_q[CT_MST] & ctrl_q[CT_SSIN];
  assign mode_o.cpol = ctrl_q[CT_CPOL];
  assign mode_o.cpha = ctrl_q[CT_CPHA];
  assign len_code_o  = fmt_q;
  assign ctrl_o      = ctrl_q;
  assign irq_o       = done_q & ctrl_q[CT_IE];
endmodule

// File: rtl/spi_slave_eng.sv
module spi_slave_eng
  import spi_slv_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          sck_i,
  input  logic          ss_n_i,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  output logic          irq_o
);
  localparam int LENW = $clog2(DW);

  logic [2:0]      pins_s;
  logic            sck_s, ss_n_s, mosi_s;
  logic            slave_mode, busy, ev_done, ev_abort;
  clk_mode_t       mode;
  logic [LENW-1:0] len_code, cnt;
  logic [LENW:0]   nbits;
  logic [DW-1:0]   tx_data, rx_char;
  logic [CT_W-1:0] ctrl;
  logic [ST_W-1:0] stat;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sck_i, ss_n_i, mosi_i}),
    .q_o(pins_s)
  );
  assign {sck_s, ss_n_s, mosi_s} = pins_s;

  spi_slv_regs #(.DW(DW), .LENW(LENW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ev_done_i(ev_done), .ev_abort_i(ev_abort), .ev_rx_i(rx_char),
    .busy_i(busy), .ss_n_s_i(ss_n_s),
    .tx_data_o(tx_data), .slave_o(slave_mode), .mode_o(mode), .len_code_o(len_code),
    .ctrl_o(ctrl), .stat_o(stat), .irq_o(irq_o)
  );

  spi_slv_shift #(.DW(DW), .LENW(LENW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .active_i(slave_mode), .mode_i(mode), .len_code_i(len_code), .tx_data_i(tx_data),
    .sck_s_i(sck_s), .ss_n_s_i(ss_n_s), .mosi_s_i(mosi_s),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .busy_o(busy),
    .done_o(ev_done), .abort_o(ev_abort), .rx_o(rx_char),
    .cnt_o(cnt), .nbits_o(nbits)
  );
endmodule

module spi_slave_eng_chk
  import spi_slv_pkg::*;
#(
  parameter int DW = 8,
  parameter int LENW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr_i,
  input logic [1:0]      reg_addr_i,
  input logic [DW-1:0]   reg_wdata_i,
  input logic            irq_o,
  input logic            miso_oe_o,
  input logic            busy,
  input logic            ev_done,
  input logic            ev_abort,
  input logic [ST_W-1:0] stat,
  input logic [CT_W-1:0] ctrl,
  input logic            ss_n_s,
  input logic [DW-1:0]   tx_data,
  input logic [LENW-1:0] cnt,
  input logic [LENW:0]   nbits
);
  // R2
  oe_in_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe_o |-> (ctrl[CT_EN] && !ctrl[CT_MST] && ctrl[CT_SSIN] && !ss_n_s));
  // R6
  ovr_on_busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_DATA && busy) |=> stat[ST_OVR]);
  // R6
  tx_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_DATA && busy) |=> $stable(tx_data));
  // R9
  done_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_STAT && reg_wdata_i[ST_DONE] && !ev_done && !ev_abort)
    |=> !stat[ST_DONE]);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ctrl[CT_IE] && stat[ST_DONE]));
  // R7
  fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CT_EN] && ctrl[CT_MST] && !ss_n_s) |=> stat[ST_FLT]);
  // R8
  abort_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (stat[ST_ABT] && stat[ST_DONE]));
  // R3
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> stat[ST_DONE]);
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt} < nbits));
endmodule

bind spi_slave_eng spi_slave_eng_chk #(.DW(DW), .LENW(LENW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .irq_o(irq_o), .miso_oe_o(miso_oe_o), .busy(busy),
  .ev_done(ev_done), .ev_abort(ev_abort), .stat(stat), .ctrl(ctrl), .ss_n_s(ss_n_s),
  .tx_data(tx_data), .cnt(cnt), .nbits(nbits)
);

// File: tb/sim_spi_slave_eng.sv
`timescale 1ns/1ps
module sim_spi_slave_eng;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rd;
  logic sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic miso, oe, irq;
  int n_tot = 0, n_bad = 0;
  bit fin = 1'b0;

  always #4 clk = ~clk;

  spi_slave_eng u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(oe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wd = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rd;
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  // one character as master: returns bits seen on MISO
  task automatic run_char(input bit cpol, input bit cpha, input int n,
                          input logic [7:0] mo, output logic [7:0] mi);
    mi = 8'd0;
    for (int i = n - 1; i >= 0; i--) begin
      if (!cpha) begin
        mosi = mo[i];
        @(negedge clk);
        mi = {mi[6:0], miso};
        sck = ~cpol; half();
        sck = cpol; repeat (3) @(negedge clk);
      end else begin
        sck = ~cpol; mosi = mo[i]; half();
        mi = {mi[6:0], miso};
        sck = cpol; half();
      end
    end
  endtask

  logic [7:0] v, mi, tx, mo, msk;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd_reg(2'd1, v); chk("R9 reset status", v, 8'h00);
    rd_reg(2'd0, v); chk("R3 reset data", v, 8'h00);
    chk("R10 reset irq", irq, 1'b0);
    chk("R2 reset oe", oe, 1'b0);

    // sweep polarity, phase and every length code
    for (int cp = 0; cp < 4; cp++) begin
      for (int code = 0; code < 8; code++) begin
        automatic bit cpol = cp[0];
        automatic bit cpha = cp[1];
        automatic int n = (code == 0) ? 8 : code;
        msk = 8'((1 << n) - 1);
        tx  = 8'(8'h96 ^ (code * 29) ^ (cp * 71));
        mo  = 8'(~tx + code * 13 + cp);
        sck = cpol;
        wr_reg(2'd2, 8'h25 | (8'(cpol) << 3) | (8'(cpha) << 4));
        wr_reg(2'd3, 8'(code));
        wr_reg(2'd0, tx);
        wr_reg(2'd1, 8'h0F);
        chk("R2 oe idle", oe, 1'b0);
        ss_n = 1'b0; half();
        chk("R2 oe selected", oe, 1'b1);
        run_char(cpol, cpha, n, mo, mi);
        ss_n = 1'b1; repeat (6) @(negedge clk);
        chk($sformatf("R4 R11 miso cp%0d len%0d", cp, n), mi, tx & msk);
        rd_reg(2'd0, v);
        chk($sformatf("R3 R4 rx cp%0d len%0d", cp, n), v, mo & msk);
        rd_reg(2'd1, v);
        chk($sformatf("R3 status cp%0d len%0d", cp, n), v, 8'h01);
        chk("R10 irq after done", irq, 1'b1);
        chk("R2 oe released", oe, 1'b0);
      end
    end

    // two characters under one select, both phases
    for (int ph = 0; ph < 2; ph++) begin
      sck = 1'b0;
      wr_reg(2'd2, 8'h25 | (8'(ph) << 4));
      wr_reg(2'd3, 8'd0);
      wr_reg(2'd0, 8'h3C);
      wr_reg(2'd1, 8'h0F);
      ss_n = 1'b0; half();
      run_char(1'b0, 1'(ph), 8, 8'h81, mi);
      chk("R5 first char miso", mi, 8'h3C);
      rd_reg(2'd0, v); chk("R5 first char rx", v, 8'h81);
      run_char(1'b0, 1'(ph), 8, 8'h7E, mi);
      chk("R5 second char repeats tx", mi, 8'h3C);
      ss_n = 1'b1; repeat (6) @(negedge clk);
      rd_reg(2'd0, v); chk("R5 second char rx", v, 8'h7E);
    end

    // collision
    wr_reg(2'd2, 8'h05);
    wr_reg(2'd3, 8'd0);
    wr_reg(2'd0, 8'hC3);
    wr_reg(2'd1, 8'h0F);
    ss_n = 1'b0; half();
    wr_reg(2'd0, 8'h5A);
    rd_reg(2'd1, v); chk("R6 collision flag with busy", v, 8'h12);
    ss_n = 1'b1; repeat (6) @(negedge clk);
    rd_reg(2'd1, v); chk("R6 collision sticky, no abort", v, 8'h02);
    ss_n = 1'b0; half();
    run_char(1'b0, 1'b0, 8, 8'h11, mi);
    ss_n = 1'b1; repeat (6) @(negedge clk);
    chk("R6 tx unchanged by collision", mi, 8'hC3);
    rd_reg(2'd1, v); chk("R3 status after transfer", v, 8'h03);
    chk("R10 irq masked", irq, 1'b0);
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd1, v); chk("R9 write zero keeps flags", v, 8'h03);
    wr_reg(2'd1, 8'h02);
    rd_reg(2'd1, v); chk("R9 clear collision only", v, 8'h01);
    wr_reg(2'd1, 8'h01);
    rd_reg(2'd1, v); chk("R9 clear done", v, 8'h00);

    // abort mid-character
    wr_reg(2'd2, 8'h25);
    ss_n = 1'b0; half();
    run_char(1'b0, 1'b0, 3, 8'hFF, mi);
    ss_n = 1'b1; repeat (6) @(negedge clk);
    rd_reg(2'd1, v); chk("R8 abort and done", v, 8'h05);
    chk("R10 irq on abort", irq, 1'b1);
    rd_reg(2'd0, v); chk("R8 rx unchanged", v, 8'h11);
    wr_reg(2'd1, 8'h04);
    rd_reg(2'd1, v); chk("R9 clear abort", v, 8'h01);
    ss_n = 1'b0; half();
    run_char(1'b0, 1'b0, 8, 8'hE7, mi);
    ss_n = 1'b1; repeat (6) @(negedge clk);
    chk("R8 restart miso", mi, 8'hC3);
    rd_reg(2'd0, v); chk("R8 restart rx", v, 8'hE7);

    // mode fault as master
    wr_reg(2'd2, 8'h03);
    wr_reg(2'd1, 8'h0F);
    ss_n = 1'b0; half();
    rd_reg(2'd1, v); chk("R7 fault flag", v, 8'h08);
    chk("R1 oe off as master", oe, 1'b0);
    run_char(1'b0, 1'b0, 8, 8'h55, mi);
    ss_n = 1'b1; repeat (6) @(negedge clk);
    rd_reg(2'd1, v); chk("R1 no done as master", v, 8'h08);
    wr_reg(2'd1, 8'h08);
    rd_reg(2'd1, v); chk("R9 clear fault", v, 8'h00);

    // select pin not an input, and unit disabled
    for (int k = 0; k < 2; k++) begin
      wr_reg(2'd2, (k == 0) ? 8'h21 : 8'h24);
      ss_n = 1'b0; half();
      chk("R1 oe off when not slave", oe, 1'b0);
      run_char(1'b0, 1'b0, 8, 8'hAA, mi);
      ss_n = 1'b1; repeat (6) @(negedge clk);
      rd_reg(2'd1, v); chk("R1 no flags when not slave", v, 8'h00);
      chk("R1 no irq when not slave", irq, 1'b0);
    end
    rd_reg(2'd0, v); chk("R1 rx untouched", v, 8'hE7);

    fin = 1'b1;
    $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_tot++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
      $finish;
    end
  end
endmodule